// File: doc/BRIEF.md
# Striped Four-Bank Dual-Master SRAM

This block is an on-chip word memory that a CPU port and a DMA port share. The storage is split into four independent 32-bit banks, and each bank has its own access path. Word addresses are spread over the banks in stripes. A run of four consecutive words sits in one bank. The next run of four goes to the next bank, and the pattern wraps after four stripes. Both ports can reach every bank. Two requests that land in different banks are served in the same cycle. When both ports want the same bank, the CPU port takes it and the DMA port waits.

Each port uses a valid/ready handshake. A request is accepted in a cycle where valid and ready are both high, and it must be held stable until then. Read data comes back in the cycle after acceptance, marked by a one-cycle read-valid strobe for that port. A bank that was written in one cycle cannot be read in the very next cycle. Any port that tries to read that bank is held off for exactly one cycle. A read of any other bank goes ahead at once.

Top module: `striped_bank_sram`

## Requirements
- R1: While reset is high and in the first cycle after it, both ready outputs are high when the matching valid is low, and both read-valid strobes are low.
- R2: The bank of a word address is address bits [3:2]. Requests from the two ports to different banks, with no other stall, are both accepted in the same cycle.
- R3: A word written at an in-range address is returned unchanged by a later read of that address from either port. Rows inside a bank are addressed by the remaining bits {addr[ADDR_W-1:4], addr[1:0]}.
- R4: When both ports present in-range requests to the same bank, the DMA ready is low and the CPU request is served. The held DMA request is accepted in the first later cycle where neither a CPU clash nor a hazard stalls it.
- R5: A read to a bank written in the previous cycle, by either port, is stalled (ready low) for exactly one cycle.
- R6: A read in the cycle after a write to a different bank is not stalled.
- R7: An accepted read raises that port's read-valid for exactly the next cycle, with its data. No read-valid is raised without an accepted read.
- R8: Addresses at or above DEPTH are always ready and use no bank. A write to such an address changes no stored word, and a read returns zero with read-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | CPU request present |
| cpu_write | input | 1 | CPU request is a write (0 = read) |
| cpu_addr | input | ADDR_W | CPU word address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_ready | output | 1 | CPU request can be accepted this cycle |
| cpu_rvalid | output | 1 | CPU read data valid |
| cpu_rdata | output | DATA_W | CPU read data |
| dma_valid | input | 1 | DMA request present |
| dma_write | input | 1 | DMA request is a write (0 = read) |
| dma_addr | input | ADDR_W | DMA word address |
| dma_wdata | input | DATA_W | DMA write data |
| dma_ready | output | 1 | DMA request can be accepted this cycle |
| dma_rvalid | output | 1 | DMA read data valid |
| dma_rdata | output | DATA_W | DMA read data |

## Verification
In a single cycle the DMA port can meet a bank clash with the CPU and a write-then-read hazard on its own bank. In the same cycle, the CPU port can be stalled by a hazard while it still holds the bank against the DMA. The bench raises these cases with directed pairs: same-bank reads, a write followed by a read of the same bank from the other port, and a write followed by a read of a different bank. Long random traffic then packs the cases together. A behavioural model keeps a word map and a last-written-bank set, and each cycle it predicts both ready lines and the data and strobes due next cycle. The DUT is checked against that model on every clock.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int NUM_BANKS  = 4;
  localparam int BANK_W     = $clog2(NUM_BANKS);
  localparam int BANK_LSB   = 2;
  localparam int STRIPE_LSB = BANK_LSB + BANK_W;
  typedef logic [BANK_W-1:0] bank_t;
endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DEPTH  = 256,
  parameter int ROW_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output bank_t             bank,
  output logic [ROW_W-1:0]  row,
  output logic              in_range
);
  // stripe number above the bank field, word-in-stripe below it
  assign bank     = addr[BANK_LSB +: BANK_W];
  assign row      = ROW_W'({addr[ADDR_W-1:STRIPE_LSB], addr[BANK_LSB-1:0]});
  assign in_range = ({1'b0, addr} < (ADDR_W+1)'(DEPTH));
endmodule

// File: rtl/sbs_arbiter.sv
module sbs_arbiter
  import sbs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cpu_valid,
  input  logic  cpu_write,
  input  logic  cpu_inr,
  input  bank_t cpu_bank,
  input  logic  dma_valid,
  input  logic  dma_write,
  input  logic  dma_inr,
  input  bank_t dma_bank,
  output logic  cpu_ready,
  output logic  dma_ready,
  output logic  cpu_go,
  output logic  dma_go
);
  logic [NUM_BANKS-1:0] wr_last;
  logic cpu_claim, dma_claim, cpu_raw, dma_raw, clash;

  // CPU owns its bank whenever it presents an in-range request
  assign cpu_claim = cpu_valid & cpu_inr;
  assign dma_claim = dma_valid & dma_inr;
  assign cpu_raw   = cpu_claim & ~cpu_write & wr_last[cpu_bank];
  assign dma_raw   = dma_claim & ~dma_write & wr_last[dma_bank];
  assign clash     = cpu_claim & dma_claim & (cpu_bank == dma_bank);

  assign cpu_ready = ~cpu_raw;
  assign dma_ready = ~(clash | dma_raw);
  assign cpu_go    = cpu_claim & ~cpu_raw;
  assign dma_go    = dma_claim & ~clash & ~dma_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_last <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        wr_last[b] <= (cpu_go & cpu_write & (cpu_bank == bank_t'(b))) |
                      (dma_go & dma_write & (dma_bank == bank_t'(b)));
      end
    end
  end
endmodule

// File: rtl/sbs_bank.sv
module sbs_bank #(
  parameter int DATA_W = 32,
  parameter int ROWS   = 64,
  parameter int ROW_W  = 6
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [0:ROWS-1];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wdata;
      else    rdata    <= mem[row];
    end
  end
endmodule

// File: rtl/striped_bank_sram.sv
module striped_bank_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              dma_valid,
  input  logic              dma_write,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic              dma_ready,
  output logic              dma_rvalid,
  output logic [DATA_W-1:0] dma_rdata
);
  localparam int ROWS  = DEPTH / NUM_BANKS;
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;

  bank_t             cpu_bank, dma_bank, cpu_rsel, dma_rsel;
  logic [ROW_W-1:0]  cpu_row, dma_row;
  logic              cpu_inr, dma_inr, cpu_go, dma_go, cpu_rinr, dma_rinr;
  logic [DATA_W-1:0] bank_rd [NUM_BANKS];

  sbs_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .ROW_W(ROW_W)) cpu_dec_i (
    .addr(cpu_addr), .bank(cpu_bank), .row(cpu_row), .in_range(cpu_inr));
  sbs_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .ROW_W(ROW_W)) dma_dec_i (
    .addr(dma_addr), .bank(dma_bank), .row(dma_row), .in_range(dma_inr));

  sbs_arbiter arb_i (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_inr(cpu_inr), .cpu_bank(cpu_bank),
    .dma_valid(dma_valid), .dma_write(dma_write), .dma_inr(dma_inr), .dma_bank(dma_bank),
    .cpu_ready(cpu_ready), .dma_ready(dma_ready), .cpu_go(cpu_go), .dma_go(dma_go));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              use_cpu, use_dma;
    logic              b_en, b_we;
    logic [ROW_W-1:0]  b_row;
    logic [DATA_W-1:0] b_wdata;

    assign use_cpu = cpu_go & (cpu_bank == bank_t'(b));
    assign use_dma = dma_go & (dma_bank == bank_t'(b));
    assign b_en    = use_cpu | use_dma;
    assign b_we    = use_cpu ? cpu_write : dma_write;
    assign b_row   = use_cpu ? cpu_row   : dma_row;
    assign b_wdata = use_cpu ? cpu_wdata : dma_wdata;

    sbs_bank #(.DATA_W(DATA_W), .ROWS(ROWS), .ROW_W(ROW_W)) mem_i (
      .clk(clk), .en(b_en), .we(b_we), .row(b_row), .wdata(b_wdata),
      .rdata(bank_rd[b]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rvalid <= 1'b0;
      dma_rvalid <= 1'b0;
      cpu_rsel   <= '0;
      dma_rsel   <= '0;
      cpu_rinr   <= 1'b0;
      dma_rinr   <= 1'b0;
    end else begin
      cpu_rvalid <= cpu_valid & cpu_ready & ~cpu_write;
      dma_rvalid <= dma_valid & dma_ready & ~dma_write;
      cpu_rsel   <= cpu_bank;
      dma_rsel   <= dma_bank;
      cpu_rinr   <= cpu_inr;
      dma_rinr   <= dma_inr;
    end
  end

  assign cpu_rdata = cpu_rinr ? bank_rd[cpu_rsel] : '0;
  assign dma_rdata = dma_rinr ? bank_rd[dma_rsel] : '0;
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_valid,
  input logic              cpu_write,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic              cpu_rvalid,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              dma_valid,
  input logic              dma_write,
  input logic [ADDR_W-1:0] dma_addr,
  input logic              dma_ready,
  input logic              dma_rvalid,
  input logic [DATA_W-1:0] dma_rdata
);
  logic cin, din;
  assign cin = (int'(cpu_addr) < DEPTH);
  assign din = (int'(dma_addr) < DEPTH);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!cpu_rvalid && !dma_rvalid));

  a_r4_cpu_wins: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && dma_valid && cin && din && cpu_addr[3:2] == dma_addr[3:2]) |-> !dma_ready);

  a_r5_cpu_raw_stall: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cpu_valid && cpu_ready && cpu_write && cin) &&
     cpu_valid && !cpu_write && cin && cpu_addr[3:2] == $past(cpu_addr[3:2])) |-> !cpu_ready);

  a_r7_cpu_rvalid: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_ready && !cpu_write) |=> cpu_rvalid);

  a_r7_cpu_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !(cpu_valid && cpu_ready && !cpu_write) |=> !cpu_rvalid);

  a_r7_dma_rvalid: assert property (@(posedge clk) disable iff (rst)
    (dma_valid && dma_ready && !dma_write) |=> dma_rvalid);

  a_r7_dma_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !(dma_valid && dma_ready && !dma_write) |=> !dma_rvalid);

  a_r8_oor_ready: assert property (@(posedge clk) disable iff (rst)
    ((cpu_valid && !cin) |-> cpu_ready) and ((dma_valid && !din) |-> dma_ready));

  a_r8_cpu_oor_zero: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_ready && !cpu_write && !cin) |=> (cpu_rdata == '0));

  a_r8_dma_oor_zero: assert property (@(posedge clk) disable iff (rst)
    (dma_valid && dma_ready && !dma_write && !din) |=> (dma_rdata == '0));
endmodule

bind striped_bank_sram sbs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (.*);

// File: tb/striped_bank_sram_tb.sv
module striped_bank_sram_tb_top;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 256;

  typedef struct packed {
    logic              v;
    logic              w;
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d;
  } req_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_valid = 1'b0, cpu_write = 1'b0, dma_valid = 1'b0, dma_write = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0, dma_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0, dma_wdata = '0;
  logic cpu_ready, cpu_rvalid, dma_ready, dma_rvalid;
  logic [DATA_W-1:0] cpu_rdata, dma_rdata;

  always #4 clk = ~clk;

  striped_bank_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  req_t qc[$], qd[$];
  req_t cur_c = '0, cur_d = '0;
  bit c_acc = 0, d_acc = 0;
  logic [DATA_W-1:0] mem [int];
  logic [3:0] wf = '0;
  bit exp_crv = 0, exp_drv = 0, exp_ck = 0, exp_dk = 0, exp_coor = 0, exp_door = 0;
  logic [DATA_W-1:0] exp_cd = '0, exp_dd = '0;

  task automatic check(bit ok, string tag, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(bit to_dma, bit v, bit w, int a, logic [DATA_W-1:0] d);
    req_t r;
    r.v = v; r.w = w; r.a = ADDR_W'(a); r.d = d;
    if (to_dma) qd.push_back(r); else qc.push_back(r);
  endtask

  task automatic step();
    logic [1:0] cb, db;
    bit cin, din, c_raw, d_raw, clash, ecr, edr;
    logic [3:0] nwf;
    string ctag, dtag;
    @(negedge clk);
    // results of the previous cycle
    check(cpu_rvalid === exp_crv, "R7", "cpu_rvalid", 32'(cpu_rvalid), 32'(exp_crv));
    if (exp_crv && exp_ck)
      check(cpu_rdata === exp_cd, exp_coor ? "R8" : "R3", "cpu_rdata", cpu_rdata, exp_cd);
    check(dma_rvalid === exp_drv, "R7", "dma_rvalid", 32'(dma_rvalid), 32'(exp_drv));
    if (exp_drv && exp_dk)
      check(dma_rdata === exp_dd, exp_door ? "R8" : "R3", "dma_rdata", dma_rdata, exp_dd);
    // next requests; a stalled one is held
    if (!cur_c.v || c_acc) cur_c = (qc.size() > 0) ? qc.pop_front() : '0;
    if (!cur_d.v || d_acc) cur_d = (qd.size() > 0) ? qd.pop_front() : '0;
    cpu_valid = cur_c.v; cpu_write = cur_c.w; cpu_addr = cur_c.a; cpu_wdata = cur_c.d;
    dma_valid = cur_d.v; dma_write = cur_d.w; dma_addr = cur_d.a; dma_wdata = cur_d.d;
    #1;
    cb = cur_c.a[3:2]; db = cur_d.a[3:2];
    cin = int'(cur_c.a) < DEPTH; din = int'(cur_d.a) < DEPTH;
    c_raw = cur_c.v && cin && !cur_c.w && wf[cb];
    d_raw = cur_d.v && din && !cur_d.w && wf[db];
    clash = cur_c.v && cin && cur_d.v && din && (cb == db);
    ecr = !c_raw;
    edr = !(clash || d_raw);
    ctag = c_raw ? "R5" : (!cin && cur_c.v) ? "R8" : (cur_c.v && !cur_c.w && wf != 0) ? "R6" : "R2";
    dtag = clash ? "R4" : d_raw ? "R5" : (!din && cur_d.v) ? "R8" :
           (cur_d.v && !cur_d.w && wf != 0) ? "R6" : "R2";
    check(cpu_ready === ecr, ctag, "cpu_ready", 32'(cpu_ready), 32'(ecr));
    check(dma_ready === edr, dtag, "dma_ready", 32'(dma_ready), 32'(edr));
    c_acc = cur_c.v && ecr;
    d_acc = cur_d.v && edr;
    exp_crv = c_acc && !cur_c.w; exp_coor = !cin;
    exp_ck = !cin || mem.exists(int'(cur_c.a));
    exp_cd = !cin ? '0 : (mem.exists(int'(cur_c.a)) ? mem[int'(cur_c.a)] : '0);
    exp_drv = d_acc && !cur_d.w; exp_door = !din;
    exp_dk = !din || mem.exists(int'(cur_d.a));
    exp_dd = !din ? '0 : (mem.exists(int'(cur_d.a)) ? mem[int'(cur_d.a)] : '0);
    nwf = '0;
    if (c_acc && cur_c.w && cin) begin mem[int'(cur_c.a)] = cur_c.d; nwf[cb] = 1'b1; end
    if (d_acc && cur_d.w && din) begin mem[int'(cur_d.a)] = cur_d.d; nwf[db] = 1'b1; end
    wf = nwf;
  endtask

  task automatic drain();
    while (qc.size() > 0 || qd.size() > 0 || (cur_c.v && !c_acc) || (cur_d.v && !d_acc)) step();
    repeat (2) step();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: idle outputs after reset
    check(cpu_ready === 1'b1, "R1", "cpu_ready", 32'(cpu_ready), 32'd1);
    check(dma_ready === 1'b1, "R1", "dma_ready", 32'(dma_ready), 32'd1);
    check(cpu_rvalid === 1'b0, "R1", "cpu_rvalid", 32'(cpu_rvalid), 32'd0);
    check(dma_rvalid === 1'b0, "R1", "dma_rvalid", 32'(dma_rvalid), 32'd0);

    // fill words 0..63 from the CPU, 64..127 from the DMA (R3)
    for (int i = 0; i < 64; i++) begin
      push(0, 1, 1, i, 32'hC000_0000 + i);
      push(1, 1, 1, 64 + i, 32'hD000_0000 + i);
    end
    drain();
    // R4: same-bank reads, words 5 and 6 both in bank 1
    push(0, 1, 0, 5, '0); push(1, 1, 0, 6, '0);
    drain();
    // R2: different banks in parallel, word 8 in bank 2, word 12 in bank 3
    push(0, 1, 0, 8, '0); push(1, 1, 0, 12, '0);
    drain();
    // R5: CPU write bank 0 then CPU read bank 0
    push(0, 1, 1, 0, 32'h1111_0000); push(0, 1, 0, 1, '0);
    push(1, 0, 0, 0, '0);            push(1, 0, 0, 0, '0);
    drain();
    // R5: DMA write bank 0 then CPU read bank 0
    push(1, 1, 1, 16, 32'h2222_0000); push(1, 0, 0, 0, '0);
    push(0, 0, 0, 0, '0);             push(0, 1, 0, 2, '0);
    drain();
    // R6: write bank 0 then read bank 1
    push(0, 1, 1, 3, 32'h3333_0000); push(0, 1, 0, 4, '0);
    drain();
    // R8: out-of-range write must not alias word 44; out-of-range reads give zero
    push(0, 1, 1, 44, 32'h4444_0000); push(0, 1, 1, 300, 32'hDEAD_BEEF);
    push(0, 1, 0, 300, '0);           push(0, 1, 0, 44, '0);
    push(1, 1, 0, 256, '0);
    drain();
    // random mixed traffic
    for (int i = 0; i < 1500; i++) begin
      for (int p = 0; p < 2; p++) begin
        int a;
        a = (($urandom % 16) == 0) ? 256 + int'($urandom % 700) : int'($urandom % 64);
        push(p[0], ($urandom % 4) != 0, $urandom % 2, a, $urandom);
      end
    end
    drain();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule